// File: doc/BRIEF.md
# Trellis State Metric Recursion Unit

This block advances the state metrics of an eight-state recursive systematic convolutional code by one trellis stage per clock. The code it follows has a feedback polynomial 1+D^2+D^3 and a feedforward polynomial 1+D+D^3. A single set of eight add-compare-select lanes serves both recursion directions. A direction input picks the wiring. In forward mode each lane combines the two predecessors of its state. In backward mode each lane combines the two successors.

Each clock can carry one stage of soft input: a systematic LLR, a parity LLR and an a-priori LLR. The block clamps these inputs and forms the four branch metrics internally. It merges the two candidates with a max-star approximation that uses a clipped linear correction. It then re-references all eight results to state 0 and stores them as saturated 10-bit values. A start pulse loads initial metrics from a small table. If a stage arrives in the same clock as the start pulse, that stage is computed on top of the fresh initial metrics, so a new recursion begins without a bubble.

Top module: `smr_recursion_unit`

## Requirements
- R1: While `rst` is high on a clock edge, the edge clears `out_valid` to 0 and all eight state metrics to 0.
- R2: Each LLR input is an 8-bit two's complement value. It is clamped to the 7-bit range [-64, 63] (units of 1/8) before use.
- R3: The branch metric for input bit u and parity bit p is floor((su*(Ls+La) + sp*Lp)/2), where su, sp = +1 for bit 1 and -1 for bit 0. Ls, La and Lp are the clamped systematic, a-priori and parity LLRs.
- R4: A state number is {r1,r2,r3}, with r1 as bit 2. For input u, the feedback bit is a = u^r2^r3, the parity is a^r1^r3 and the next state is {a,r1,r2}. In forward mode (`dir`=0), the metric of state n combines the two transitions that lead into n.
- R5: In backward mode (`dir`=1), the metric of state s combines, for u = 0 and u = 1, the stored metric of the next state plus the branch metric of that transition.
- R6: Two candidates x and y combine as max(x,y) + max(0, 6 - floor(|x-y|/2)).
- R7: After each stage, the raw metric of state 0 is subtracted from every state's raw metric. Each result is saturated to [-512, 511], so state 0 always reads 0 after a stage.
- R8: A start pulse with `dir`=0 loads metric 0 for state 0 and NEG_INIT for every other state.
- R9: A start pulse with `dir`=1 loads metrics from the backward table. With `init_sel`=1 it loads state 0 at 0 and the others at NEG_INIT. With `init_sel`=0 it loads all states at 0.
- R10: When `start` and `in_valid` are high in the same clock, that stage is computed from the initial metrics selected by R8 or R9.
- R11: `out_valid` equals `in_valid` delayed by one clock. A clock with neither `start` nor `in_valid` leaves the metrics unchanged.
- R12: With `in_valid` held high, a new stage result appears every clock, and the direction may change from one stage to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load initial metrics |
| init_sel | input | 1 | Backward table row: 1 terminated, 0 open |
| dir | input | 1 | 0 forward, 1 backward |
| in_valid | input | 1 | Stage inputs valid this clock |
| sys_llr | input | 8 | Systematic LLR, two's complement |
| par_llr | input | 8 | Parity LLR, two's complement |
| apr_llr | input | 8 | A-priori LLR, two's complement |
| out_valid | output | 1 | Metrics updated by a stage |
| sm_out | output | 80 | State metric i in bits [10*i+9 : 10*i] |

## Verification
Every result lands on the first rising edge after its inputs are presented, with no extra register on the path. This holds for stage metrics, `out_valid`, loads from the start table and the reset state. The bench therefore drives each stage on a falling edge. It compares `out_valid` and all eight metrics on the next falling edge, against a bench model that applies the clamp, branch, max-star and re-reference rules to its own copy of the metrics. Idle clocks are checked the same way: the expected metrics are the unchanged previous values.

// File: rtl/smr_pkg.sv
package smr_pkg;

  localparam int unsigned N_ST = 8;
  localparam int unsigned ST_W = 3;

  // state = {r1, r2, r3}; feedback 1+D^2+D^3, feedforward 1+D+D^3
  function automatic logic [ST_W-1:0] smr_next(input logic [ST_W-1:0] s, input logic u);
    logic fb;
    fb = u ^ s[1] ^ s[0];
    return {fb, s[2], s[1]};
  endfunction

  function automatic logic smr_par(input logic [ST_W-1:0] s, input logic u);
    logic fb;
    fb = u ^ s[1] ^ s[0];
    return fb ^ s[2] ^ s[0];
  endfunction

  // predecessor of state sn is {sn[1:0], b}; input bit on that branch
  function automatic logic smr_fwd_u(input logic [ST_W-1:0] sn, input logic b);
    return sn[2] ^ sn[0] ^ b;
  endfunction

  // parity bit on the branch {sn[1:0], b} -> sn
  function automatic logic smr_fwd_p(input logic [ST_W-1:0] sn, input logic b);
    return sn[2] ^ sn[1] ^ b;
  endfunction

endpackage

// File: rtl/smr_branch.sv
module smr_branch #(
  parameter int IN_W  = 8,
  parameter int LLR_W = 7,
  parameter int BM_W  = LLR_W + 1
) (
  input  logic signed [IN_W-1:0] sys_i,
  input  logic signed [IN_W-1:0] par_i,
  input  logic signed [IN_W-1:0] apr_i,
  output logic signed [BM_W-1:0] gam_o [4]
);

  localparam int HI    = 2 ** (LLR_W - 1) - 1;
  localparam int LO    = -(2 ** (LLR_W - 1));
  localparam int SUM_W = LLR_W + 2;

  function automatic logic signed [LLR_W-1:0] clamp(input logic signed [IN_W-1:0] x);
    if (x > IN_W'(HI))      return LLR_W'(HI);
    else if (x < IN_W'(LO)) return LLR_W'(LO);
    else                    return x[LLR_W-1:0];
  endfunction

  logic signed [LLR_W-1:0] ls, lp, la;
  logic signed [SUM_W-1:0] s_sum, p_ext;

  always_comb begin
    ls    = clamp(sys_i);
    lp    = clamp(par_i);
    la    = clamp(apr_i);
    s_sum = SUM_W'(ls) + SUM_W'(la);
    p_ext = SUM_W'(lp);
  end

  // index = {u, p}
  for (genvar k = 0; k < 4; k++) begin : g_bm
    localparam bit UB = ((k / 2) % 2) == 1;
    localparam bit PB = (k % 2) == 1;
    logic signed [SUM_W-1:0] v;
    always_comb begin
      v = (UB ? s_sum : -s_sum) + (PB ? p_ext : -p_ext);
      gam_o[k] = BM_W'(v >>> 1);
    end
  end

endmodule

// File: rtl/smr_acs.sv
module smr_acs #(
  parameter int SM_W  = 10,
  parameter int BM_W  = 8,
  parameter int EXT_W = 13,
  parameter int LN2_Q = 6
) (
  input  logic signed [SM_W-1:0]  ma_i,
  input  logic signed [SM_W-1:0]  mb_i,
  input  logic signed [BM_W-1:0]  ga_i,
  input  logic signed [BM_W-1:0]  gb_i,
  output logic signed [EXT_W-1:0] res_o
);

  logic signed [EXT_W-1:0] ca, cb, diff, mag, half, corr, corr_c, big;

  always_comb begin
    ca     = EXT_W'(ma_i) + EXT_W'(ga_i);
    cb     = EXT_W'(mb_i) + EXT_W'(gb_i);
    diff   = ca - cb;
    mag    = (diff < 0) ? -diff : diff;
    half   = mag >>> 1;
    corr   = EXT_W'(LN2_Q) - half;
    corr_c = (corr < 0) ? '0 : corr;
    big    = (ca >= cb) ? ca : cb;
    res_o  = big + corr_c;
  end

endmodule

// File: rtl/smr_norm.sv
module smr_norm #(
  parameter int N     = 8,
  parameter int SM_W  = 10,
  parameter int EXT_W = 13
) (
  input  logic signed [EXT_W-1:0] raw_i [N],
  output logic signed [SM_W-1:0]  nrm_o [N]
);

  localparam int HI = 2 ** (SM_W - 1) - 1;
  localparam int LO = -(2 ** (SM_W - 1));

  for (genvar i = 0; i < N; i++) begin : g_n
    logic signed [EXT_W-1:0] d;
    always_comb begin
      d = raw_i[i] - raw_i[0];
      if (d > EXT_W'(HI))      nrm_o[i] = SM_W'(HI);
      else if (d < EXT_W'(LO)) nrm_o[i] = SM_W'(LO);
      else                     nrm_o[i] = d[SM_W-1:0];
    end
  end

endmodule

// File: rtl/smr_recursion_unit.sv
module smr_recursion_unit
  import smr_pkg::*;
#(
  parameter int IN_W     = 8,
  parameter int LLR_W    = 7,
  parameter int SM_W     = 10,
  parameter int NEG_INIT = -256,
  parameter int LN2_Q    = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 init_sel,
  input  logic                 dir,
  input  logic                 in_valid,
  input  logic [IN_W-1:0]      sys_llr,
  input  logic [IN_W-1:0]      par_llr,
  input  logic [IN_W-1:0]      apr_llr,
  output logic                 out_valid,
  output logic [N_ST*SM_W-1:0] sm_out
);

  localparam int BM_W  = LLR_W + 1;
  localparam int EXT_W = SM_W + 3;
  localparam int ROWS  = 3;

  logic signed [BM_W-1:0]  gam    [4];
  logic signed [SM_W-1:0]  init_lut [ROWS][N_ST];
  logic signed [SM_W-1:0]  base_m [N_ST];
  logic signed [SM_W-1:0]  metric_q [N_ST];
  logic signed [SM_W-1:0]  nrm    [N_ST];
  logic signed [EXT_W-1:0] raw    [N_ST];
  logic [1:0]              row;
  logic                    ov_q;

  smr_branch #(.IN_W(IN_W), .LLR_W(LLR_W), .BM_W(BM_W)) u_branch (
    .sys_i(sys_llr),
    .par_i(par_llr),
    .apr_i(apr_llr),
    .gam_o(gam)
  );

  // start table: row 0 forward, row 1 backward open, row 2 backward terminated
  always_comb begin
    for (int i = 0; i < N_ST; i++) begin
      init_lut[0][i] = (i == 0) ? '0 : SM_W'(NEG_INIT);
      init_lut[1][i] = '0;
      init_lut[2][i] = (i == 0) ? '0 : SM_W'(NEG_INIT);
    end
    row = dir ? (init_sel ? 2'd2 : 2'd1) : 2'd0;
    for (int i = 0; i < N_ST; i++)
      base_m[i] = start ? init_lut[row][i] : metric_q[i];
  end

  for (genvar st = 0; st < N_ST; st++) begin : g_st
    localparam logic [ST_W-1:0] SV = ST_W'(st);
    localparam int FP0 = (st % 4) * 2;
    localparam int FP1 = FP0 + 1;
    localparam int FG0 = 2 * int'(smr_fwd_u(SV, 1'b0)) + int'(smr_fwd_p(SV, 1'b0));
    localparam int FG1 = 2 * int'(smr_fwd_u(SV, 1'b1)) + int'(smr_fwd_p(SV, 1'b1));
    localparam int BN0 = int'(smr_next(SV, 1'b0));
    localparam int BN1 = int'(smr_next(SV, 1'b1));
    localparam int BG0 = int'(smr_par(SV, 1'b0));
    localparam int BG1 = 2 + int'(smr_par(SV, 1'b1));

    logic signed [SM_W-1:0] ma, mb;
    logic signed [BM_W-1:0] ga, gb;

    always_comb begin
      if (dir) begin
        ma = base_m[BN0];
        mb = base_m[BN1];
        ga = gam[BG0];
        gb = gam[BG1];
      end else begin
        ma = base_m[FP0];
        mb = base_m[FP1];
        ga = gam[FG0];
        gb = gam[FG1];
      end
    end

    smr_acs #(.SM_W(SM_W), .BM_W(BM_W), .EXT_W(EXT_W), .LN2_Q(LN2_Q)) u_acs (
      .ma_i(ma),
      .mb_i(mb),
      .ga_i(ga),
      .gb_i(gb),
      .res_o(raw[st])
    );

    assign sm_out[st*SM_W +: SM_W] = metric_q[st];
  end

  smr_norm #(.N(N_ST), .SM_W(SM_W), .EXT_W(EXT_W)) u_norm (
    .raw_i(raw),
    .nrm_o(nrm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ov_q <= 1'b0;
      for (int i = 0; i < N_ST; i++) metric_q[i] <= '0;
    end else begin
      ov_q <= in_valid;
      if (in_valid) begin
        for (int i = 0; i < N_ST; i++) metric_q[i] <= nrm[i];
      end else if (start) begin
        for (int i = 0; i < N_ST; i++) metric_q[i] <= base_m[i];
      end
    end
  end

  assign out_valid = ov_q;

endmodule

// File: rtl/smr_recursion_chk.sv
module smr_recursion_chk #(
  parameter int SM_W     = 10,
  parameter int NEG_INIT = -256
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              dir,
  input logic              in_valid,
  input logic              out_valid,
  input logic [8*SM_W-1:0] sm_out
);

  function automatic logic [8*SM_W-1:0] fwd_vec();
    logic [8*SM_W-1:0] v;
    for (int i = 0; i < 8; i++)
      v[i*SM_W +: SM_W] = (i == 0) ? '0 : SM_W'(NEG_INIT);
    return v;
  endfunction

  localparam logic [8*SM_W-1:0] FWD_INIT = fwd_vec();

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && sm_out == '0));

  assert_valid_follow_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !start) |=> $stable(sm_out));

  assert_ref_zero_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (sm_out[SM_W-1:0] == '0));

  assert_fwd_init_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !in_valid && !dir) |=> (sm_out == FWD_INIT));

endmodule

bind smr_recursion_unit smr_recursion_chk #(.SM_W(SM_W), .NEG_INIT(NEG_INIT)) u_chk (
  .clk(clk),
  .rst(rst),
  .start(start),
  .dir(dir),
  .in_valid(in_valid),
  .out_valid(out_valid),
  .sm_out(sm_out)
);

// File: tb/smr_recursion_unit_tb.sv
`timescale 1ns/1ps
module smr_recursion_unit_tb;

  localparam int SM_W = 10;
  localparam int NEG  = -480;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, init_sel = 1'b0, dir = 1'b0, in_valid = 1'b0;
  logic [7:0] sys_llr = '0, par_llr = '0, apr_llr = '0;
  logic out_valid;
  logic [8*SM_W-1:0] sm_out;

  int total = 0;
  int bad = 0;
  int ref_m [8];
  logic [31:0] lfsr = 32'h1F2E_3D4C;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  smr_recursion_unit #(.NEG_INIT(NEG)) u_dut (
    .clk(clk), .rst(rst), .start(start), .init_sel(init_sel), .dir(dir),
    .in_valid(in_valid), .sys_llr(sys_llr), .par_llr(par_llr), .apr_llr(apr_llr),
    .out_valid(out_valid), .sm_out(sm_out)
  );

  function automatic int clampi(int x);
    return (x > 63) ? 63 : ((x < -64) ? -64 : x);
  endfunction

  function automatic int sat10(int x);
    return (x > 511) ? 511 : ((x < -512) ? -512 : x);
  endfunction

  function automatic int mstar(int x, int y);
    int d, c;
    d = (x > y) ? x - y : y - x;
    c = 6 - d / 2;
    if (c < 0) c = 0;
    return ((x > y) ? x : y) + c;
  endfunction

  function automatic int nxt(int s, int u);
    int r1, r2, r3, fb;
    r1 = (s >> 2) & 1; r2 = (s >> 1) & 1; r3 = s & 1;
    fb = u ^ r2 ^ r3;
    return fb * 4 + r1 * 2 + r2;
  endfunction

  function automatic int parb(int s, int u);
    int r1, r2, r3, fb;
    r1 = (s >> 2) & 1; r2 = (s >> 1) & 1; r3 = s & 1;
    fb = u ^ r2 ^ r3;
    return fb ^ r1 ^ r3;
  endfunction

  function automatic int gamv(int u, int p, int ssum, int lp);
    int v;
    v = (u == 1 ? ssum : -ssum) + (p == 1 ? lp : -lp);
    return v >>> 1;
  endfunction

  function automatic int got(int i);
    return int'($signed(sm_out[i*SM_W +: SM_W]));
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit st, bit isel, bit d, bit iv, int s, int p, int a, string tag);
    int base [8];
    int raw [8];
    int nw [8];
    int ls, lp, la, ssum;
    start = st; init_sel = isel; dir = d; in_valid = iv;
    sys_llr = 8'(s); par_llr = 8'(p); apr_llr = 8'(a);
    for (int i = 0; i < 8; i++) begin
      if (st) begin
        if (!d)        base[i] = (i == 0) ? 0 : NEG;
        else if (isel) base[i] = (i == 0) ? 0 : NEG;
        else           base[i] = 0;
      end else base[i] = ref_m[i];
    end
    if (iv) begin
      ls = clampi(int'($signed(8'(s))));
      lp = clampi(int'($signed(8'(p))));
      la = clampi(int'($signed(8'(a))));
      ssum = ls + la;
      if (d) begin
        for (int q = 0; q < 8; q++)
          raw[q] = mstar(base[nxt(q, 0)] + gamv(0, parb(q, 0), ssum, lp),
                         base[nxt(q, 1)] + gamv(1, parb(q, 1), ssum, lp));
      end else begin
        for (int n = 0; n < 8; n++) begin
          int c [2];
          int k;
          k = 0;
          for (int q = 0; q < 8; q++)
            for (int u = 0; u < 2; u++)
              if (nxt(q, u) == n && k < 2) begin
                c[k] = base[q] + gamv(u, parb(q, u), ssum, lp);
                k++;
              end
          raw[n] = mstar(c[0], c[1]);
        end
      end
      for (int i = 0; i < 8; i++) nw[i] = sat10(raw[i] - raw[0]);
    end else begin
      for (int i = 0; i < 8; i++) nw[i] = base[i];
    end
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
    chk({tag, " valid"}, int'(out_valid), int'(iv));
    for (int i = 0; i < 8; i++) begin
      chk($sformatf("%s metric[%0d]", tag, i), got(i), nw[i]);
      ref_m[i] = nw[i];
    end
  endtask

  task automatic rnd(output int v);
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    v = int'($signed(lfsr[7:0]));
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int a, b, c;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", int'(out_valid), 0);
    for (int i = 0; i < 8; i++) begin
      chk("R1 metric", got(i), 0);
      ref_m[i] = 0;
    end
    rst = 1'b0;

    step(1, 0, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 5, 5, 5, "R11");
    step(0, 0, 0, 0, -9, 3, 1, "R11");
    step(0, 0, 0, 1, 0, 0, 0, "R6");
    step(1, 0, 0, 1, 20, 0, 0, "R3");
    step(1, 0, 0, 1, 0, 14, 0, "R3");
    step(1, 0, 0, 1, 0, 0, -22, "R10");
    step(0, 0, 0, 1, 127, -128, 100, "R2");
    step(0, 0, 0, 1, -100, 90, -128, "R2");

    for (int t = 0; t < 60; t++) begin
      rnd(a); rnd(b); rnd(c);
      step(0, 0, 0, 1, a, b, c, "R4");
    end

    step(1, 1, 1, 0, 0, 0, 0, "R9");
    for (int t = 0; t < 60; t++) begin
      rnd(a); rnd(b); rnd(c);
      step(0, 0, 1, 1, a, b, c, "R5");
    end

    step(1, 0, 1, 0, 0, 0, 0, "R9");
    step(1, 0, 1, 1, 11, -7, 3, "R10");
    step(1, 1, 1, 1, -30, 25, 9, "R10");

    step(1, 0, 0, 0, 0, 0, 0, "R8");
    for (int t = 0; t < 20; t++)
      step(0, 0, 0, 1, 63, -64, 63, "R7");
    for (int t = 0; t < 20; t++)
      step(0, 0, 1, 1, -64, 63, -64, "R7");

    for (int t = 0; t < 200; t++) begin
      rnd(a); rnd(b); rnd(c);
      step(((lfsr[9:8]) == 2'b00), lfsr[10], lfsr[11], (lfsr[13:12] != 2'b00),
           a, b, c, "R12");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule